// File: doc/BRIEF.md
# DMA Page and Address Generator

This block builds the physical memory address for each of four DMA channels. A transfer engine supplies the channel number, the current 16-bit transfer address, a byte offset, a length and a direction flag. The block combines these with two per-channel page registers and returns a registered 31-bit physical address. The low page supplies address bits 23:16. An optional high page supplies bits 30:24.

Software programs the page registers over a byte-wide port bus. The bus carries a 3-bit port index, a bank select that picks the low or high page bank, write data, and read and write strobes. The port index reaches a channel through a fixed and irregular map that has unused holes. A parameter selects the word-addressing variant, which doubles the programmed address. A second parameter removes the high page bank.

Both the port bus and the transfer inputs are plain sampled control pins with no handshake. Every strobe is taken in the cycle in which it is high and is never back-pressured. The address output is a registered function of the inputs that were present one cycle earlier.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset, every page register reads 0x00, `pg_rdata` is 0x00 and `phys_addr` is 0.
- R2: The port index selects a channel as follows: index 7 selects channel 0, index 3 selects channel 1, index 1 selects channel 2 and index 2 selects channel 3. A write to a mapped index stores all 8 bits in the selected bank (`pg_hi_sel` 0 = low page, 1 = high page), and a later read of that index and bank returns the stored value.
- R3: The indices 0, 4, 5 and 6 are unmapped. A write to one of them changes no page register, and a read from one of them returns 0x00.
- R4: `phys_addr[23:16]` is the low page of `xfer_chan`, and `phys_addr[30:24]` is bits 6:0 of its high page.
- R5: A high page register stores all 8 bits and reads them back, but its bit 7 never reaches `phys_addr`.
- R6: When `xfer_decr` is 0, `phys_addr[15:0]` = (B + `xfer_pos`) mod 2^16. B is the scaled transfer address defined in R8.
- R7: When `xfer_decr` is 1 (this flag mirrors bit 5 of the channel mode), `phys_addr[15:0]` = (B − `xfer_pos` − `xfer_len`) mod 2^16. A carry or borrow never reaches the page fields.
- R8: With `WORD_SHIFT` = 0, B = `xfer_base`. With `WORD_SHIFT` = 1, B = (`xfer_base` << 1) mod 2^16, which gives word addressing.
- R9: With `HIGH_PAGE_EN` = 0, a write with `pg_hi_sel` = 1 has no effect, a read with `pg_hi_sel` = 1 returns 0x00, and `phys_addr[30:24]` is always 0.
- R10: `phys_addr` reflects the transfer inputs and page values sampled at the previous clock edge. `pg_rdata` is updated one cycle after `pg_rd` and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_hi_sel | input | 1 | Bank select: 0 = low page, 1 = high page |
| pg_idx | input | 3 | Page port index |
| pg_wdata | input | 8 | Page write data |
| pg_wr | input | 1 | Page write strobe |
| pg_rd | input | 1 | Page read strobe |
| pg_rdata | output | 8 | Registered page read data |
| xfer_chan | input | 2 | Channel of the current transfer |
| xfer_decr | input | 1 | Decrement direction (mode bit 5) |
| xfer_base | input | 16 | Current programmed transfer address |
| xfer_pos | input | 16 | Byte offset within the transfer |
| xfer_len | input | 16 | Transfer length, used in decrement mode |
| phys_addr | output | 31 | Registered physical address |

## Verification
A wrongly decoded port index stores a value in the wrong channel's page. This shows up either when that channel's port is read back, one cycle after the strobe, or in bits 30:16 of `phys_addr` on the next address request for that channel. A wrong direction or scaling shows up at once in the low 16 bits of the next registered address, most visibly at the wrap points 0x0000 and 0xFFFF. The bench therefore reads every mapped and unmapped port after its writes. It also drives the two parameter variants side by side from the same stimulus, so that scaling and high-page removal are compared in the same cycle.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

  localparam int PORT_W = 3;
  localparam int MAP_CH_W = 2;

  typedef struct packed {
    logic                hit;
    logic [MAP_CH_W-1:0] ch;
  } chan_hit_t;

  // Fixed, irregular port-index to channel map; holes report no hit.
  function automatic chan_hit_t port_to_chan(input logic [PORT_W-1:0] idx);
    chan_hit_t r;
    r = '{hit: 1'b0, ch: '0};
    case (idx)
      3'd7: r = '{hit: 1'b1, ch: 2'd0};
      3'd3: r = '{hit: 1'b1, ch: 2'd1};
      3'd1: r = '{hit: 1'b1, ch: 2'd2};
      3'd2: r = '{hit: 1'b1, ch: 2'd3};
      default: r = '{hit: 1'b0, ch: 2'd0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_pg_port_decode.sv
module dma_pg_port_decode
  import dma_pg_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic [PORT_W-1:0] port_idx,
  output logic              hit,
  output logic [CH_W-1:0]   ch
);

  chan_hit_t dec;

  always_comb begin
    dec = port_to_chan(port_idx);
    hit = dec.hit;
    ch  = CH_W'(dec.ch);
  end

endmodule

// File: rtl/dma_pg_page_bank.sv
module dma_pg_page_bank #(
  parameter int NUM_CH   = 4,
  parameter int BYTE_W   = 8,
  parameter int HPAGE_EN = 1,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic                           sel_hi,
  input  logic                           hit,
  input  logic [CH_W-1:0]                ch,
  input  logic [BYTE_W-1:0]              wr_data,
  output logic [BYTE_W-1:0]              rd_data,
  output logic [NUM_CH-1:0][BYTE_W-1:0]  lo_pages,
  output logic [NUM_CH-1:0][BYTE_W-1:0]  hi_pages
);

  logic [NUM_CH-1:0][BYTE_W-1:0] lo_q;
  logic [NUM_CH-1:0][BYTE_W-1:0] hi_q;
  logic                          lo_we;
  logic [BYTE_W-1:0]             rd_nxt;

  assign lo_we = wr_en & hit & ~sel_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_we) begin
      lo_q[ch] <= wr_data;
    end
  end

  generate
    if (HPAGE_EN != 0) begin : g_hi_bank
      logic hi_we;
      assign hi_we = wr_en & hit & sel_hi;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hi_q <= '0;
        end else if (hi_we) begin
          hi_q[ch] <= wr_data;
        end
      end

      // R2
      hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && sel_hi) |=> hi_q[$past(ch)] == $past(wr_data));
    end else begin : g_no_hi_bank
      assign hi_q = '0;

      // R9
      hpage_off_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_hi) |=> rd_data == '0);
    end
  endgenerate

  always_comb begin
    rd_nxt = '0;
    if (hit) begin
      rd_nxt = sel_hi ? hi_q[ch] : lo_q[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_nxt;
    end
  end

  assign lo_pages = lo_q;
  assign hi_pages = hi_q;

  // R2
  lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && !sel_hi) |=> lo_q[$past(ch)] == $past(wr_data));

  // R3
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(lo_q) && $stable(hi_q)));

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rd_data == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/dma_pg_addr_calc.sv
module dma_pg_addr_calc #(
  parameter int ADDR_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int HPAGE_KEEP = 7,
  parameter int WORD_SHIFT = 0,
  localparam int PHYS_W    = HPAGE_KEEP + BYTE_W + ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HPAGE_KEEP-1:0] hi_page,
  input  logic [BYTE_W-1:0]     lo_page,
  input  logic [ADDR_W-1:0]     base,
  input  logic [ADDR_W-1:0]     pos,
  input  logic [ADDR_W-1:0]     len,
  input  logic                  decr,
  output logic [PHYS_W-1:0]     phys_addr
);

  logic [ADDR_W-1:0] base_sc;
  logic [ADDR_W-1:0] low_nxt;
  logic              seen_clk;

  generate
    if (WORD_SHIFT == 0) begin : g_byte_addr
      assign base_sc = base;
    end else begin : g_word_addr
      assign base_sc = {base[ADDR_W-1-WORD_SHIFT:0], {WORD_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (decr) begin
      low_nxt = base_sc - pos - len;
    end else begin
      low_nxt = base_sc + pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_addr <= '0;
      seen_clk  <= 1'b0;
    end else begin
      phys_addr <= {hi_page, lo_page, low_nxt};
      seen_clk  <= 1'b1;
    end
  end

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $stable(hi_page) && $stable(lo_page) && $stable(base) &&
     $stable(pos) && $stable(len) && $stable(decr)) |=> $stable(phys_addr));

  // R6
  incr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!decr && pos == '0) |=> phys_addr[ADDR_W-1:0] == $past(base_sc));

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int ADDR_W       = 16,
  parameter int BYTE_W       = 8,
  parameter int HPAGE_KEEP   = 7,
  parameter int NUM_CH       = 4,
  parameter int WORD_SHIFT   = 0,
  parameter int HIGH_PAGE_EN = 1,
  localparam int CH_W        = $clog2(NUM_CH),
  localparam int PHYS_W      = HPAGE_KEEP + BYTE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_hi_sel,
  input  logic [2:0]        pg_idx,
  input  logic [BYTE_W-1:0] pg_wdata,
  input  logic              pg_wr,
  input  logic              pg_rd,
  output logic [BYTE_W-1:0] pg_rdata,
  input  logic [CH_W-1:0]   xfer_chan,
  input  logic              xfer_decr,
  input  logic [ADDR_W-1:0] xfer_base,
  input  logic [ADDR_W-1:0] xfer_pos,
  input  logic [ADDR_W-1:0] xfer_len,
  output logic [PHYS_W-1:0] phys_addr
);

  logic                          map_hit;
  logic [CH_W-1:0]               map_ch;
  logic [NUM_CH-1:0][BYTE_W-1:0] lo_pages;
  logic [NUM_CH-1:0][BYTE_W-1:0] hi_pages;
  logic [BYTE_W-1:0]             sel_lo;
  logic [BYTE_W-1:0]             sel_hi_full;
  logic                          seen_q;

  dma_pg_port_decode #(.CH_W(CH_W)) u_decode (
    .port_idx (pg_idx),
    .hit      (map_hit),
    .ch       (map_ch)
  );

  dma_pg_page_bank #(
    .NUM_CH   (NUM_CH),
    .BYTE_W   (BYTE_W),
    .HPAGE_EN (HIGH_PAGE_EN)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pg_wr),
    .rd_en    (pg_rd),
    .sel_hi   (pg_hi_sel),
    .hit      (map_hit),
    .ch       (map_ch),
    .wr_data  (pg_wdata),
    .rd_data  (pg_rdata),
    .lo_pages (lo_pages),
    .hi_pages (hi_pages)
  );

  assign sel_lo      = lo_pages[xfer_chan];
  assign sel_hi_full = hi_pages[xfer_chan];

  dma_pg_addr_calc #(
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .HPAGE_KEEP (HPAGE_KEEP),
    .WORD_SHIFT (WORD_SHIFT)
  ) u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_page   (sel_hi_full[HPAGE_KEEP-1:0]),
    .lo_page   (sel_lo),
    .base      (xfer_base),
    .pos       (xfer_pos),
    .len       (xfer_len),
    .decr      (xfer_decr),
    .phys_addr (phys_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R4
  lo_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> phys_addr[ADDR_W +: BYTE_W] == $past(lo_pages[xfer_chan]));

  // R9
  hi_field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HIGH_PAGE_EN == 0) |-> phys_addr[PHYS_W-1 -: HPAGE_KEEP] == '0);

endmodule

// File: tb/dma_page_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_page_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_hi_sel = 1'b0;
  logic [2:0]  pg_idx = '0;
  logic [7:0]  pg_wdata = '0;
  logic        pg_wr = 1'b0;
  logic        pg_rd = 1'b0;
  logic [7:0]  rdata_a, rdata_b;
  logic [1:0]  xfer_chan = '0;
  logic        xfer_decr = 1'b0;
  logic [15:0] xfer_base = '0;
  logic [15:0] xfer_pos = '0;
  logic [15:0] xfer_len = '0;
  logic [30:0] addr_a, addr_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];

  always #4 clk = ~clk;

  // Variant A: byte addressing, high page present.
  dma_page_addr_gen #(.WORD_SHIFT(0), .HIGH_PAGE_EN(1)) u_dma_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .pg_hi_sel(pg_hi_sel), .pg_idx(pg_idx),
    .pg_wdata(pg_wdata), .pg_wr(pg_wr), .pg_rd(pg_rd), .pg_rdata(rdata_a),
    .xfer_chan(xfer_chan), .xfer_decr(xfer_decr), .xfer_base(xfer_base),
    .xfer_pos(xfer_pos), .xfer_len(xfer_len), .phys_addr(addr_a));

  // Variant B: word addressing, no high page.
  dma_page_addr_gen #(.WORD_SHIFT(1), .HIGH_PAGE_EN(0)) u_dma_page_addr_gen_w (
    .clk(clk), .rst_n(rst_n), .pg_hi_sel(pg_hi_sel), .pg_idx(pg_idx),
    .pg_wdata(pg_wdata), .pg_wr(pg_wr), .pg_rd(pg_rd), .pg_rdata(rdata_b),
    .xfer_chan(xfer_chan), .xfer_decr(xfer_decr), .xfer_base(xfer_base),
    .xfer_pos(xfer_pos), .xfer_len(xfer_len), .phys_addr(addr_b));

  function automatic int map_ch(input logic [2:0] idx);
    case (idx)
      3'd7: return 0;
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [30:0] exp_addr(input logic [7:0] lo, input logic [7:0] hi,
      input logic [15:0] base, input logic [15:0] pos, input logic [15:0] len,
      input logic decr, input int ws, input int hpen);
    logic [15:0] b, low;
    logic [6:0]  h;
    b   = (ws != 0) ? {base[14:0], 1'b0} : base;
    low = decr ? (b - pos - len) : (b + pos);
    h   = (hpen != 0) ? hi[6:0] : 7'd0;
    return {h, lo, low};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic hi, input logic [2:0] idx, input logic [7:0] d);
    int c;
    @(negedge clk);
    pg_hi_sel = hi; pg_idx = idx; pg_wdata = d; pg_wr = 1'b1;
    @(negedge clk);
    pg_wr = 1'b0;
    c = map_ch(idx);
    if (c >= 0) begin
      if (hi) m_hi[c] = d;
      else    m_lo[c] = d;
    end
  endtask

  task automatic do_read(input logic hi, input logic [2:0] idx, input string req);
    int c;
    logic [7:0] ea, eb;
    @(negedge clk);
    pg_hi_sel = hi; pg_idx = idx; pg_rd = 1'b1;
    @(negedge clk);
    pg_rd = 1'b0;
    c = map_ch(idx);
    ea = (c < 0) ? 8'h00 : (hi ? m_hi[c] : m_lo[c]);
    eb = (c < 0 || hi) ? 8'h00 : m_lo[c];
    chk(req, {24'd0, rdata_a}, {24'd0, ea});
    chk({req, " R9 variant"}, {24'd0, rdata_b}, {24'd0, eb});
  endtask

  task automatic do_addr(input logic [1:0] ch, input logic decr, input logic [15:0] base,
      input logic [15:0] pos, input logic [15:0] len, input string req);
    @(negedge clk);
    xfer_chan = ch; xfer_decr = decr; xfer_base = base; xfer_pos = pos; xfer_len = len;
    @(negedge clk);
    chk(req, {1'b0, addr_a}, {1'b0, exp_addr(m_lo[ch], m_hi[ch], base, pos, len, decr, 0, 1)});
    chk({req, " R8 R9 variant"}, {1'b0, addr_b},
        {1'b0, exp_addr(m_lo[ch], m_hi[ch], base, pos, len, decr, 1, 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [30:0] prev;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_lo[i] = 8'h00; m_hi[i] = 8'h00; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", {1'b0, addr_a}, 32'd0);
    chk("R1 rdata", {24'd0, rdata_a}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      do_read(1'b0, 3'(k), "R1 lo reset read");
      do_read(1'b1, 3'(k), "R1 hi reset read");
    end

    // R2 map: distinct values per index
    do_write(1'b0, 3'd7, 8'hA0);
    do_write(1'b0, 3'd3, 8'hB1);
    do_write(1'b0, 3'd1, 8'hC2);
    do_write(1'b0, 3'd2, 8'hD3);
    do_write(1'b1, 3'd7, 8'h10);
    do_write(1'b1, 3'd3, 8'h21);
    do_write(1'b1, 3'd1, 8'h32);
    do_write(1'b1, 3'd2, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      do_read(1'b0, 3'(k), "R2 lo map read");
      do_read(1'b1, 3'(k), "R2 hi map read");
    end
    for (int c = 0; c < 4; c++) do_addr(2'(c), 1'b0, 16'h1234, 16'h0001, 16'h0, "R4 page fields");

    // R3 unmapped writes ignored
    do_write(1'b0, 3'd0, 8'h55);
    do_write(1'b1, 3'd4, 8'h66);
    do_write(1'b0, 3'd5, 8'h77);
    do_write(1'b1, 3'd6, 8'h88);
    for (int k = 0; k < 8; k++) begin
      do_read(1'b0, 3'(k), "R3 after unmapped writes lo");
      do_read(1'b1, 3'(k), "R3 after unmapped writes hi");
    end

    // R5 high bit 7 dropped (channel 3 high page = FF)
    do_addr(2'd3, 1'b0, 16'h0000, 16'h0000, 16'h0, "R5 hi bit7 dropped");
    chk("R5 field", {25'd0, addr_a[30:24]}, 32'h7F);

    // R6 / R7 wrap corners
    do_addr(2'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0, "R6 incr wrap");
    do_addr(2'd1, 1'b1, 16'h0000, 16'h0001, 16'h0001, "R7 decr wrap");
    do_addr(2'd2, 1'b1, 16'h1000, 16'h0010, 16'h0020, "R7 decr");
    do_addr(2'd3, 1'b0, 16'h8000, 16'h0003, 16'h0, "R8 shift drop msb");

    // R10 latency: output unchanged before the capturing edge
    do_addr(2'd0, 1'b0, 16'h0100, 16'h0000, 16'h0, "R10 setup");
    prev = addr_a;
    @(negedge clk);
    xfer_base = 16'h0200;
    #1;
    chk("R10 before edge", {1'b0, addr_a}, {1'b0, prev});
    @(negedge clk);
    chk("R10 after edge", {1'b0, addr_a},
        {1'b0, exp_addr(m_lo[0], m_hi[0], 16'h0200, 16'h0, 16'h0, 1'b0, 0, 1)});
    // R10 read data holds without strobe
    do_read(1'b0, 3'd3, "R10 read");
    repeat (2) @(negedge clk);
    chk("R10 rdata hold", {24'd0, rdata_a}, {24'd0, m_lo[1]});

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 2));
      if (op == 0)
        do_write(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 8'($urandom));
      else if (op == 1)
        do_read(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), "R2 R3 random read");
      else
        do_addr(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 16'($urandom),
                16'($urandom), 16'($urandom), "R6 R7 random addr");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule